// File: doc/BRIEF.md
# Bus Watchpoint Trigger with Capture

The block watches a processor bus carrying address, control and data and compares every valid address tenure against a set of programmed watchpoints (two by default). Each watchpoint has a value and a per-bit mask for the address and for the control field, plus a 4-bit occurrence countdown. A qualifying match decrements the countdown. When an armed, enabled watchpoint matches with its count already at zero, it expires.

On an expiry the block raises a single-cycle trigger pulse for external debug or trace logic. It also freezes a snapshot of the address, control and data seen on that bus cycle into capture registers, sets a sticky status bit and records which watchpoint was reported. The watchpoint that fired disarms itself. It stays idle until software rewrites its configuration with the arm bit set.

Top module: `wpt_trigger`

## Requirements
- R1: A watchpoint matches only when bus_valid_i is high and, for every bit whose mask bit is 1, the bus address and control equal the programmed values. Mask bits of 0 are ignored. Cycles with bus_valid_i low never count.
- R2: A watchpoint loaded with count N expires on its (N+1)th qualifying match. A count of 0 expires on the first match. Each earlier match decrements the remaining count, which reads back in config bits [3:0].
- R3: An expiry sampled at a rising edge makes trig_o high for exactly the following cycle. No trigger occurs without an expiry.
- R4: At an expiry the address, control and data of that bus cycle are captured into registers at offsets 0x12, 0x13 and 0x14. These hold their values until the next expiry.
- R5: A watchpoint that expired is disarmed (config bit 4 reads 0), and further matches have no effect. Writing its config register with bit 4 set loads bits [3:0] as the new count and re-arms it.
- R6: Status at offset 0x11 holds one sticky fired bit per watchpoint in bits [NUM_WP-1:0]. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Bits [9:8] give the index of the last reported watchpoint.
- R7: If several watchpoints expire in the same cycle, one trigger pulse is produced. All of their status bits are set, and the lowest index (watchpoint 0) is reported.
- R8: Offset 0x10 bit k enables watchpoint k. A disabled watchpoint neither counts nor expires, and its count and armed state are unchanged.
- R9: After reset trig_o is low, every register reads 0 and all watchpoints are disarmed.
- R10: Watchpoint k occupies offsets 4k to 4k+3. These hold, in order: the address value, the address mask, the control value in bits [CW-1:0] with the control mask in bits [16+CW-1:16], and the config register. Reads are combinational on reg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Valid address tenure on the watched bus |
| bus_addr_i | input | AW | Watched bus address |
| bus_ctrl_i | input | CW | Watched bus control (type, size and similar) |
| bus_data_i | input | DW | Watched bus data |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| trig_o | output | 1 | Single-cycle trigger pulse |

## Verification
The bench targets masked address bits that differ from the programmed value, control bits that differ inside the mask, and cycles with valid low. A design that compared the wrong bits would count too early or never. It drives the count down to zero and also loads zero directly. An off-by-one countdown would show up there as a trigger one match early or late on the scoreboard. Matches after a firing and on a disabled watchpoint must leave count, capture and trigger untouched, which catches a design that does not disarm or does not gate with the enable. Two watchpoints expiring together must give one pulse, both status bits and index 0. A partial write-1-to-clear must keep the bits that were not written.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int REG_AW   = 5;
  localparam int REG_DW   = 32;
  localparam int CTRL_MSK_LSB = 16;
  localparam int CFG_ARM_BIT  = 4;

  localparam logic [REG_AW-1:0] OFS_ENABLE   = 5'h10;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 5'h11;
  localparam logic [REG_AW-1:0] OFS_CAP_ADDR = 5'h12;
  localparam logic [REG_AW-1:0] OFS_CAP_CTRL = 5'h13;
  localparam logic [REG_AW-1:0] OFS_CAP_DATA = 5'h14;

  typedef enum logic [1:0] {
    SUB_ADDR_VAL = 2'd0,
    SUB_ADDR_MSK = 2'd1,
    SUB_CTRL     = 2'd2,
    SUB_CFG      = 2'd3
  } wp_sub_e;
endpackage

// File: rtl/wpt_channel.sv
module wpt_channel
  import wpt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 8,
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sub_i,
  input  logic [REG_DW-1:0] wr_data_i,
  input  logic [1:0]        rd_sub_i,
  output logic [REG_DW-1:0] rd_data_o,
  input  logic              enable_i,
  input  logic              bus_valid_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [CW-1:0]     bus_ctrl_i,
  output logic              expire_o
);
  logic [AW-1:0]    addr_val_q, addr_msk_q;
  logic [CW-1:0]    ctrl_val_q, ctrl_msk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             hit, qualify, cfg_we;

  assign hit = bus_valid_i
             && (((bus_addr_i ^ addr_val_q) & addr_msk_q) == '0)
             && (((bus_ctrl_i ^ ctrl_val_q) & ctrl_msk_q) == '0);
  assign qualify  = hit && armed_q && enable_i;
  assign expire_o = qualify && (cnt_q == '0);
  assign cfg_we   = wr_en_i && (wr_sub_i == SUB_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_val_q <= '0;
      addr_msk_q <= '0;
      ctrl_val_q <= '0;
      ctrl_msk_q <= '0;
    end else if (wr_en_i) begin
      case (wr_sub_i)
        SUB_ADDR_VAL: addr_val_q <= wr_data_i[AW-1:0];
        SUB_ADDR_MSK: addr_msk_q <= wr_data_i[AW-1:0];
        SUB_CTRL: begin
          ctrl_val_q <= wr_data_i[CW-1:0];
          ctrl_msk_q <= wr_data_i[CTRL_MSK_LSB +: CW];
        end
        default: ;
      endcase
    end
  end

  // config write wins over a same-cycle match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cfg_we) begin
      cnt_q   <= wr_data_i[CNT_W-1:0];
      armed_q <= wr_data_i[CFG_ARM_BIT];
    end else if (qualify) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_sub_i)
      SUB_ADDR_VAL: rd_data_o[AW-1:0] = addr_val_q;
      SUB_ADDR_MSK: rd_data_o[AW-1:0] = addr_msk_q;
      SUB_CTRL: begin
        rd_data_o[CW-1:0]             = ctrl_val_q;
        rd_data_o[CTRL_MSK_LSB +: CW] = ctrl_msk_q;
      end
      default: begin
        rd_data_o[CNT_W-1:0]   = cnt_q;
        rd_data_o[CFG_ARM_BIT] = armed_q;
      end
    endcase
  end

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qualify && (cnt_q != '0) && !cfg_we |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !cfg_we |=> !armed_q);
  p_disabled_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && !cfg_we |=> $stable(cnt_q) && $stable(armed_q));
  p_invalid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i && !cfg_we |=> $stable(cnt_q) && $stable(armed_q));
endmodule

// File: rtl/wpt_report.sv
module wpt_report
  import wpt_pkg::*;
#(
  parameter int NUM_WP = 2,
  parameter int AW     = 32,
  parameter int CW     = 8,
  parameter int DW     = 32,
  parameter int IDW    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WP-1:0] expire_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [CW-1:0]     bus_ctrl_i,
  input  logic [DW-1:0]     bus_data_i,
  input  logic              clr_we_i,
  input  logic [NUM_WP-1:0] clr_mask_i,
  output logic              trig_o,
  output logic [NUM_WP-1:0] status_o,
  output logic [IDW-1:0]    rep_id_o,
  output logic [AW-1:0]     cap_addr_o,
  output logic [CW-1:0]     cap_ctrl_o,
  output logic [DW-1:0]     cap_data_o
);
  logic            any_exp;
  logic [IDW-1:0]  pick;
  logic [NUM_WP-1:0] clr;

  assign any_exp = |expire_i;
  assign clr     = clr_we_i ? clr_mask_i : '0;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_WP - 1; i >= 0; i--) begin
      if (expire_i[i]) pick = IDW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o     <= 1'b0;
      status_o   <= '0;
      rep_id_o   <= '0;
      cap_addr_o <= '0;
      cap_ctrl_o <= '0;
      cap_data_o <= '0;
    end else begin
      trig_o   <= any_exp;
      status_o <= (status_o & ~clr) | expire_i;
      if (any_exp) begin
        rep_id_o   <= pick;
        cap_addr_o <= bus_addr_i;
        cap_ctrl_o <= bus_ctrl_i;
        cap_data_o <= bus_data_i;
      end
    end
  end

  p_trig_fire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_exp |=> trig_o);
  p_trig_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_exp |=> !trig_o);
  p_cap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_exp |=> $stable(cap_addr_o) && $stable(cap_ctrl_o) && $stable(cap_data_o));
  p_status_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_exp |=> (status_o & $past(expire_i)) == $past(expire_i));
  p_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i[0] |=> rep_id_o == '0);
endmodule

// File: rtl/wpt_trigger.sv
module wpt_trigger
  import wpt_pkg::*;
#(
  parameter int NUM_WP = 2,
  parameter int AW     = 32,
  parameter int CW     = 8,
  parameter int DW     = 32,
  parameter int CNT_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_valid_i,
  input  logic [AW-1:0]       bus_addr_i,
  input  logic [CW-1:0]       bus_ctrl_i,
  input  logic [DW-1:0]       bus_data_i,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [REG_DW-1:0]   reg_wdata_i,
  output logic [REG_DW-1:0]   reg_rdata_o,
  output logic                trig_o
);
  localparam int IDW = (NUM_WP > 1) ? $clog2(NUM_WP) : 1;
  localparam int ID_LSB = 8;

  logic [NUM_WP-1:0] enable_q;
  logic [NUM_WP-1:0] expire;
  logic [NUM_WP-1:0] status;
  logic [IDW-1:0]    rep_id;
  logic [AW-1:0]     cap_addr;
  logic [CW-1:0]     cap_ctrl;
  logic [DW-1:0]     cap_data;
  logic [REG_DW-1:0] ch_rd [NUM_WP];
  logic              ch_space;

  assign ch_space = !reg_addr_i[REG_AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                enable_q <= '0;
    else if (reg_we_i && reg_addr_i == OFS_ENABLE) enable_q <= reg_wdata_i[NUM_WP-1:0];
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    wpt_channel #(.AW(AW), .CW(CW), .CNT_W(CNT_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (reg_we_i && ch_space && reg_addr_i[3:2] == 2'(g)),
      .wr_sub_i    (reg_addr_i[1:0]),
      .wr_data_i   (reg_wdata_i),
      .rd_sub_i    (reg_addr_i[1:0]),
      .rd_data_o   (ch_rd[g]),
      .enable_i    (enable_q[g]),
      .bus_valid_i (bus_valid_i),
      .bus_addr_i  (bus_addr_i),
      .bus_ctrl_i  (bus_ctrl_i),
      .expire_o    (expire[g])
    );
  end

  wpt_report #(.NUM_WP(NUM_WP), .AW(AW), .CW(CW), .DW(DW), .IDW(IDW)) u_rep (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire),
    .bus_addr_i (bus_addr_i),
    .bus_ctrl_i (bus_ctrl_i),
    .bus_data_i (bus_data_i),
    .clr_we_i   (reg_we_i && reg_addr_i == OFS_STATUS),
    .clr_mask_i (reg_wdata_i[NUM_WP-1:0]),
    .trig_o     (trig_o),
    .status_o   (status),
    .rep_id_o   (rep_id),
    .cap_addr_o (cap_addr),
    .cap_ctrl_o (cap_ctrl),
    .cap_data_o (cap_data)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (ch_space) begin
      for (int i = 0; i < NUM_WP; i++) begin
        if (reg_addr_i[3:2] == 2'(i)) reg_rdata_o = ch_rd[i];
      end
    end else begin
      case (reg_addr_i)
        OFS_ENABLE:   reg_rdata_o[NUM_WP-1:0] = enable_q;
        OFS_STATUS: begin
          reg_rdata_o[NUM_WP-1:0]     = status;
          reg_rdata_o[ID_LSB +: IDW]  = rep_id;
        end
        OFS_CAP_ADDR: reg_rdata_o[AW-1:0] = cap_addr;
        OFS_CAP_CTRL: reg_rdata_o[CW-1:0] = cap_ctrl;
        OFS_CAP_DATA: reg_rdata_o[DW-1:0] = cap_data;
        default: ;
      endcase
    end
  end

  p_trig_needs_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> status != '0);
endmodule

// File: tb/wpt_trigger_test.sv
module wpt_trigger_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic [7:0]  bus_ctrl_i = '0;
  logic [31:0] bus_data_i = '0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        trig_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int exp_q[$];
  bit done = 0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  wpt_trigger uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i),
    .bus_addr_i(bus_addr_i), .bus_ctrl_i(bus_ctrl_i), .bus_data_i(bus_data_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .trig_o(trig_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  // driver: one bus cycle, pushes the cycle where trig_o is expected
  task automatic bus(bit v, logic [31:0] a, logic [7:0] c, logic [31:0] d, bit exp_trig);
    @(negedge clk_i);
    bus_valid_i = v; bus_addr_i = a; bus_ctrl_i = c; bus_data_i = d;
    if (exp_trig) exp_q.push_back(cyc + 1);
    @(negedge clk_i);
    bus_valid_i = 1'b0;
  endtask

  // monitor: every trigger pulse must match an expected item
  always @(negedge clk_i) begin
    if (rst_ni && trig_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R3 unexpected trigger actual=1 expected=0 at cycle %0d", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL R3 trigger cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset state
    chk("R9 trig", {31'b0, trig_o}, 32'h0);
    rd("R9 status", 5'h11, 32'h0);
    rd("R9 cfg", 5'h03, 32'h0);
    rd("R9 capture", 5'h12, 32'h0);

    // R10 program wp0: addr, low nibble masked off, ctrl low nibble compared
    wr(5'h00, 32'h1000_0040);
    wr(5'h01, 32'hFFFF_FFF0);
    wr(5'h02, 32'h000F_0005);
    wr(5'h03, 32'h0000_0012);
    wr(5'h10, 32'h1);
    rd("R10 addr mask", 5'h01, 32'hFFFF_FFF0);
    rd("R10 ctrl", 5'h02, 32'h000F_0005);
    rd("R10 cfg", 5'h03, 32'h12);

    // R1 non-qualifying cycles
    bus(0, 32'h1000_0040, 8'h05, 32'h1, 0);
    rd("R1 valid low", 5'h03, 32'h12);
    bus(1, 32'h1000_0040, 8'h07, 32'h2, 0);
    rd("R1 ctrl mismatch", 5'h03, 32'h12);
    bus(1, 32'h1000_0140, 8'h05, 32'h3, 0);
    rd("R1 addr mismatch", 5'h03, 32'h12);

    // R2 countdown with masked bits differing
    bus(1, 32'h1000_004C, 8'h35, 32'h4, 0);
    rd("R2 count 1", 5'h03, 32'h11);
    bus(1, 32'h1000_0043, 8'h05, 32'h5, 0);
    rd("R2 count 0", 5'h03, 32'h10);
    bus(1, 32'h1000_0047, 8'hF5, 32'hCAFE_0001, 1);

    // R4 capture, R6 status, R5 disarm
    rd("R4 cap addr", 5'h12, 32'h1000_0047);
    rd("R4 cap ctrl", 5'h13, 32'h0000_00F5);
    rd("R4 cap data", 5'h14, 32'hCAFE_0001);
    rd("R6 status", 5'h11, 32'h0000_0001);
    rd("R5 disarmed", 5'h03, 32'h0);
    bus(1, 32'h1000_0041, 8'h05, 32'hDEAD_0000, 0);
    rd("R5 no recapture", 5'h14, 32'hCAFE_0001);
    wr(5'h11, 32'h1);
    rd("R6 w1c", 5'h11, 32'h0);

    // R8 disabled wp1 stays idle, then R2 zero count
    wr(5'h04, 32'h2000_0000);
    wr(5'h05, 32'hFFFF_FFFF);
    wr(5'h06, 32'h0);
    wr(5'h07, 32'h10);
    bus(1, 32'h2000_0000, 8'h9A, 32'h55, 0);
    rd("R8 disabled", 5'h07, 32'h10);
    wr(5'h10, 32'h3);
    bus(1, 32'h2000_0000, 8'h9A, 32'h66, 1);
    rd("R2 zero count id", 5'h11, 32'h0000_0102);
    rd("R5 wp1 disarmed", 5'h07, 32'h0);

    // R7 simultaneous expiry
    wr(5'h11, 32'h3);
    wr(5'h00, 32'h2000_0000);
    wr(5'h01, 32'hFFFF_FFFF);
    wr(5'h02, 32'h0);
    wr(5'h03, 32'h10);
    wr(5'h07, 32'h10);
    bus(1, 32'h2000_0000, 8'h3C, 32'h77, 1);
    rd("R7 status", 5'h11, 32'h0000_0003);
    rd("R7 capture", 5'h14, 32'h77);

    // R5 re-arm with count 1
    wr(5'h03, 32'h11);
    bus(1, 32'h2000_0000, 8'h01, 32'h88, 0);
    bus(1, 32'h2000_0000, 8'h02, 32'h99, 1);
    rd("R5 rearm capture", 5'h14, 32'h99);
    rd("R5 rearm disarmed", 5'h03, 32'h0);
    wr(5'h11, 32'h2);
    rd("R6 partial w1c", 5'h11, 32'h0000_0001);

    repeat (3) @(negedge clk_i);
    chk("R3 pending triggers", exp_q.size(), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule